// File: doc/BRIEF.md
# Offset Trim Calibration Sequencer

This block runs the offset-trim loop of a single current-sense gain stage. An analog comparator reports whether the residual offset at the stage output is positive or negative. The sequencer walks a signed trim code up or down until that residual is as small as the trim resolution allows. Two modes are offered. Acquisition mode steps the trim on every sample and runs without a break until the comparator sign has flipped back and forth long enough to show the trim is dithering around zero. Tracking mode is meant for every calibration after the first one. It wakes at a programmable interval and collects a batch of sign samples. It moves the trim by one step only when the batch is clearly lopsided.

The sequencer never takes a sample while an ADC conversion is in flight. It also waits until the DAC supply has been up for a programmable number of clock cycles before a run can begin. A start request that arrives while either of these interlocks is active is remembered and launched as soon as they clear.

Top module: `ofs_trim_seq`

## Requirements
- R1: While reset is active and on the first cycle after it, `trim_code` is 0, `busy` is 0 and `done` is 0.
- R2: A run begins only after `dac_pwr` has been sampled high on SETTLE_CYC consecutive rising edges. `busy` rises on the edge after that, and any low sample of `dac_pwr` restarts the count.
- R3: While `adc_busy` is sampled high, no run is accepted and no sample is taken, so `trim_code` holds its value.
- R4: A `start_req` pulse seen while idle but interlocked is kept pending, and the run starts on the first edge at which the interlock is clear.
- R5: A `start_req` that arrives while `busy` is high is dropped and does not cause a later run.
- R6: In acquisition mode each accepted sample moves the trim by exactly one step: down when `ofs_pos`=1 (residual positive) and up when `ofs_pos`=0. The first sample is taken on the edge after the run is accepted.
- R7: An acquisition run ends after 4 consecutive samples each differ in sign from the sample before them. On that edge `busy` falls and `done` rises for exactly one cycle.
- R8: The trim saturates at +31 and -32 (6-bit two's complement) and never wraps.
- R9: A tracking batch takes 16 accepted samples. With net = (count of `ofs_pos`=1) minus (count of `ofs_pos`=0), the trim steps down by one if net > 8, steps up by one if net < -8, and otherwise stays the same. `done` pulses for one cycle when the batch ends.
- R10: If `mode_track` is high when a tracking batch ends, the block waits `track_interval` cycles (at least 1) and starts the next batch, so `done` pulses are `track_interval`+16 cycles apart. If `mode_track` is low at that point, the block goes idle.
- R11: The run type is taken from `mode_track` on the accept edge. Changing it during an acquisition run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request a calibration run |
| mode_track | input | 1 | 0 = acquisition, 1 = tracking |
| adc_busy | input | 1 | ADC conversion in progress (interlock) |
| dac_pwr | input | 1 | DAC supply is up |
| ofs_pos | input | 1 | Comparator: residual offset is positive |
| track_interval | input | 16 | Cycles between tracking batches |
| trim_code | output | 6 | Signed offset trim code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run or batch |

## Verification
The bench closes the loop with a model of the gain stage, which places the residual's zero crossing at chosen offsets. It checks where acquisition settles for offsets on both sides of zero. A design that counts alternations off by one would stop one step early or late, and a design that steps in the wrong direction would never stop. Tracking batches are fed sign patterns with exactly 12 or 13, and 3 or 4, positive samples out of 16, so a greater-or-equal threshold compare shows up as a wrong step. The bench also checks the edge at which a pending start launches after the settle count, with a dropout in the middle of the count. It checks that an ADC-busy window freezes the trim, that saturation does not wrap, and the spacing of tracking batches.

// File: rtl/ofs_trim_pkg.sv
package ofs_trim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACQ   = 2'd1,
      ST_TWAIT = 2'd2,
      ST_TSAMP = 2'd3
   } cal_state_t;
endpackage

// File: rtl/ofs_settle_gate.sv
module ofs_settle_gate #(
   parameter int SETTLE_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dac_pwr,
   input  logic adc_busy,
   output logic clear_to_run
);
   logic settled;

   if (SETTLE_CYC < 0) begin : g_bad_settle
      $error("SETTLE_CYC must not be negative");
   end

   if (SETTLE_CYC == 0) begin : g_nodelay
      assign settled = dac_pwr;
   end else begin : g_count
      localparam int CW = $clog2(SETTLE_CYC + 1);
      localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (!dac_pwr)
            cnt_q <= '0;
         else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
      end

      assign settled = dac_pwr && (cnt_q == LIMIT);

      // R2
      settle_cnt_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LIMIT);
      // R2
      settle_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         settled |-> $past(dac_pwr));
   end

   assign clear_to_run = settled && !adc_busy;
endmodule

// File: rtl/ofs_trim_reg.sv
module ofs_trim_reg #(
   parameter int TRIM_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_up,
   input  logic                     step_dn,
   output logic signed [TRIM_W-1:0] trim
);
   localparam logic signed [TRIM_W-1:0] T_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
   localparam logic signed [TRIM_W-1:0] T_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
   localparam logic signed [TRIM_W-1:0] ONE   = TRIM_W'(1);

   if (TRIM_W < 2) begin : g_bad_w
      $error("TRIM_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         trim <= '0;
      else if (step_up && !step_dn && trim != T_MAX)
         trim <= trim + ONE;
      else if (step_dn && !step_up && trim != T_MIN)
         trim <= trim - ONE;
   end

   // R6
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trim == $past(trim)) || (trim == $past(trim) + ONE) || (trim == $past(trim) - ONE));
   // R8
   no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(trim) == T_MAX) |-> (trim != T_MIN));
   // R8
   no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(trim) == T_MIN) |-> (trim != T_MAX));
endmodule

// File: rtl/ofs_alt_detect.sv
module ofs_alt_detect #(
   parameter int ALT_N = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic smp_en,
   input  logic smp_pos,
   output logic conv
);
   localparam int AW = $clog2(ALT_N + 1);
   localparam logic [AW-1:0] LAST_ALT = AW'(ALT_N - 1);

   if (ALT_N < 1) begin : g_bad_alt
      $error("ALT_N must be at least 1");
   end

   logic          have_last, last_pos, flip;
   logic [AW-1:0] alt_q;

   assign flip = have_last && (smp_pos != last_pos);
   assign conv = smp_en && flip && (alt_q == LAST_ALT);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         have_last <= 1'b0;
         last_pos  <= 1'b0;
         alt_q     <= '0;
      end else if (smp_en) begin
         have_last <= 1'b1;
         last_pos  <= smp_pos;
         if (conv || !flip)
            alt_q <= '0;
         else
            alt_q <= alt_q + 1'b1;
      end
   end

   // R7
   alt_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alt_q <= LAST_ALT);
   // R7
   alt_needs_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_q != '0) |-> have_last);
endmodule

// File: rtl/ofs_batch_vote.sv
module ofs_batch_vote #(
   parameter int NSAMP  = 16,
   parameter int THRESH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic smp_en,
   input  logic smp_pos,
   output logic fin,
   output logic vote_up,
   output logic vote_dn
);
   localparam int NW = $clog2(NSAMP + 1);
   localparam int SW = NW + 1;
   localparam logic [NW-1:0]        LAST_IDX = NW'(NSAMP - 1);
   localparam logic signed [SW-1:0] TH_P     = SW'(THRESH);
   localparam logic signed [SW-1:0] TH_N     = -TH_P;
   localparam logic signed [SW-1:0] P_ONE    = SW'(1);

   if (NSAMP < 2) begin : g_bad_n
      $error("NSAMP must be at least 2");
   end
   if (THRESH < 0 || THRESH >= NSAMP) begin : g_bad_th
      $error("THRESH must lie in 0..NSAMP-1");
   end

   logic [NW-1:0]        cnt_q;
   logic signed [SW-1:0] net_q, net_nxt;

   assign net_nxt = smp_pos ? (net_q + P_ONE) : (net_q - P_ONE);
   assign fin     = smp_en && (cnt_q == LAST_IDX);
   assign vote_dn = fin && (net_nxt > TH_P);
   assign vote_up = fin && (net_nxt < TH_N);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || fin) begin
         cnt_q <= '0;
         net_q <= '0;
      end else if (smp_en) begin
         cnt_q <= cnt_q + 1'b1;
         net_q <= net_nxt;
      end
   end

   // R9
   batch_cnt_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_IDX);
   // R9
   net_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (net_q <= $signed({1'b0, cnt_q})) && (net_q >= -$signed({1'b0, cnt_q})));
endmodule

// File: rtl/ofs_trim_seq.sv
module ofs_trim_seq
   import ofs_trim_pkg::*;
#(
   parameter int TRIM_W     = 6,
   parameter int SETTLE_CYC = 50,
   parameter int ALT_N      = 4,
   parameter int NSAMP      = 16,
   parameter int THRESH     = 8,
   parameter int IVL_W      = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_req,
   input  logic                     mode_track,
   input  logic                     adc_busy,
   input  logic                     dac_pwr,
   input  logic                     ofs_pos,
   input  logic [IVL_W-1:0]         track_interval,
   output logic signed [TRIM_W-1:0] trim_code,
   output logic                     busy,
   output logic                     done
);
   if (IVL_W < 1) begin : g_bad_ivl
      $error("IVL_W must be at least 1");
   end

   cal_state_t       state_q, state_d;
   logic             pend_q, done_q;
   logic [IVL_W-1:0] ivl_q;
   logic [IVL_W:0]   ivl_inc;
   logic             ok, accept, ivl_last;
   logic             acq_en, trk_en, conv, fin, vote_up, vote_dn;
   logic             step_up, step_dn;

   ofs_settle_gate #(.SETTLE_CYC(SETTLE_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .dac_pwr(dac_pwr), .adc_busy(adc_busy),
      .clear_to_run(ok)
   );

   ofs_alt_detect #(.ALT_N(ALT_N)) u_alt (
      .clk(clk), .rst_n(rst_n), .clr(accept), .smp_en(acq_en),
      .smp_pos(ofs_pos), .conv(conv)
   );

   ofs_batch_vote #(.NSAMP(NSAMP), .THRESH(THRESH)) u_vote (
      .clk(clk), .rst_n(rst_n), .clr(accept), .smp_en(trk_en),
      .smp_pos(ofs_pos), .fin(fin), .vote_up(vote_up), .vote_dn(vote_dn)
   );

   ofs_trim_reg #(.TRIM_W(TRIM_W)) u_trim (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .trim(trim_code)
   );

   assign accept   = (state_q == ST_IDLE) && (pend_q || start_req) && ok;
   assign acq_en   = (state_q == ST_ACQ) && ok;
   assign trk_en   = (state_q == ST_TSAMP) && ok;
   assign ivl_inc  = {1'b0, ivl_q} + 1'b1;
   assign ivl_last = ivl_inc >= {1'b0, track_interval};
   assign step_up  = (acq_en && !ofs_pos) || vote_up;
   assign step_dn  = (acq_en && ofs_pos) || vote_dn;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept)   state_d = mode_track ? ST_TWAIT : ST_ACQ;
         ST_ACQ:   if (conv)     state_d = ST_IDLE;
         ST_TWAIT: if (ivl_last) state_d = ST_TSAMP;
         ST_TSAMP: if (fin)      state_d = mode_track ? ST_TWAIT : ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         ivl_q   <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= conv || fin;
         if (state_q == ST_TWAIT && !ivl_last)
            ivl_q <= ivl_inc[IVL_W-1:0];
         else
            ivl_q <= '0;
         if (accept)
            pend_q <= 1'b0;
         else if (state_q == ST_IDLE && start_req)
            pend_q <= 1'b1;
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

   // R3
   hold_on_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_busy |=> (trim_code == $past(trim_code)));
   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ok));
   // R7
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R5
   no_pend_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !pend_q);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(busy && mode_track)) |=> !done);
endmodule

// File: tb/sim_ofs_trim_seq.sv
module sim_ofs_trim_seq;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 50;
   localparam int NVEC       = 7;
   localparam int VK [NVEC] = '{16, 13, 12, 8, 4, 3, 0};
   localparam int VD [NVEC] = '{-1, -1, 0, 0, 0, 1, 1};

   logic clk = 1'b0;
   logic rst_n, start_req, mode_track, adc_busy, dac_pwr, ofs_pos;
   logic [15:0] track_interval;
   logic signed [5:0] trim_code;
   logic busy, done;

   int n_chk = 0;
   int n_fail = 0;
   int off_val = 0;
   int k_ones = 0;
   logic pattern_mode = 1'b0;
   logic [3:0] phase = '0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) phase <= phase + 4'd1;

   // stage model: closed loop around an offset, or a fixed sign pattern
   always_comb begin
      if (pattern_mode) ofs_pos = (int'(phase) < k_ones);
      else              ofs_pos = ((int'(trim_code) + off_val) > 0);
   end

   ofs_trim_seq #(.SETTLE_CYC(SETTLE)) u0 (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_track(mode_track),
      .adc_busy(adc_busy), .dac_pwr(dac_pwr), .ofs_pos(ofs_pos),
      .track_interval(track_interval), .trim_code(trim_code), .busy(busy), .done(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start_req = 1'b0; mode_track = 1'b0; adc_busy = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (SETTLE + 2) @(negedge clk);
   endtask

   task automatic pulse_start(input logic m);
      start_req = 1'b1; mode_track = m;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic wait_done(input string req, input int lim);
      int c = 0;
      while (!done && c < lim) begin
         @(negedge clk);
         c++;
      end
      chk(req, int'(done), 1);
   endtask

   function automatic int acq_end(input int off);
      return (off <= 0) ? (1 - off) : (-off);
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int t0;
      int cyc;
      rst_n = 1'b0; start_req = 1'b0; mode_track = 1'b0; adc_busy = 1'b0;
      dac_pwr = 1'b0; track_interval = 16'd5;
      repeat (3) @(negedge clk);
      chk("R1 trim in reset", int'(trim_code), 0);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 trim after reset", int'(trim_code), 0);
      chk("R1 done after reset", int'(done), 0);

      // R2 / R4: pending start waits for the settle window, dropout restarts it
      off_val = -5;
      pulse_start(1'b0);
      dac_pwr = 1'b1;
      repeat (10) @(negedge clk);
      dac_pwr = 1'b0;
      @(negedge clk);
      dac_pwr = 1'b1;
      repeat (SETTLE) @(negedge clk);
      chk("R2 busy before settle", int'(busy), 0);
      @(negedge clk);
      chk("R2 busy after settle", int'(busy), 1);
      chk("R6 no step on accept", int'(trim_code), 0);
      @(negedge clk);
      chk("R6 first step up", int'(trim_code), 1);
      pulse_start(1'b0); // R5: ignored while busy
      wait_done("R7 acq done", 200);
      chk("R7 acq end trim off=-5", int'(trim_code), acq_end(-5));
      chk("R7 busy falls with done", int'(busy), 0);
      @(negedge clk);
      chk("R7 done one cycle", int'(done), 0);
      repeat (10) @(negedge clk);
      chk("R5 start while busy dropped", int'(busy), 0);

      // R8: saturation both ways
      do_reset();
      off_val = -40;
      pulse_start(1'b0);
      repeat (100) @(negedge clk);
      chk("R8 sat high", int'(trim_code), 31);
      chk("R8 still busy at sat", int'(busy), 1);
      do_reset();
      off_val = 40;
      pulse_start(1'b0);
      repeat (100) @(negedge clk);
      chk("R8 sat low", int'(trim_code), -32);

      // acquisition endpoints; R11 mode change mid-run ignored
      for (int i = 0; i < 3; i++) begin
         int offs [3] = '{0, 3, -2};
         do_reset();
         off_val = offs[i];
         pulse_start(1'b0);
         if (i == 0) mode_track = 1'b1;
         wait_done("R7 acq done", 200);
         chk("R7 acq end trim", int'(trim_code), acq_end(offs[i]));
         repeat (3) @(negedge clk);
         chk("R11 idle after acq", int'(busy), 0);
         mode_track = 1'b0;
      end

      // R3: adc_busy freezes the trim mid-run
      do_reset();
      off_val = -20;
      pulse_start(1'b0);
      repeat (3) @(negedge clk);
      adc_busy = 1'b1;
      t0 = int'(trim_code);
      repeat (10) @(negedge clk);
      chk("R3 trim frozen", int'(trim_code), t0);
      adc_busy = 1'b0;
      wait_done("R7 acq done", 200);
      chk("R7 acq end trim off=-20", int'(trim_code), 21);

      // R4: start held while adc_busy, launched on clear
      @(negedge clk);
      adc_busy = 1'b1;
      pulse_start(1'b0);
      repeat (5) @(negedge clk);
      chk("R4 held while interlocked", int'(busy), 0);
      adc_busy = 1'b0;
      @(negedge clk);
      chk("R4 runs on clear", int'(busy), 1);
      wait_done("R7 acq done", 200);
      chk("R7 reacquire end trim", int'(trim_code), 20);

      // R9 table: single tracking batches with fixed positive counts
      pattern_mode = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         k_ones = VK[i];
         @(negedge clk);
         t0 = int'(trim_code);
         pulse_start(1'b1);
         mode_track = 1'b0;
         wait_done("R9 batch done", 100);
         chk("R9 batch step", int'(trim_code) - t0, VD[i]);
         chk("R10 idle after last batch", int'(busy), 0);
      end

      // R10: repeated batches spaced interval+16
      k_ones = 8;
      @(negedge clk);
      t0 = int'(trim_code);
      pulse_start(1'b1);
      wait_done("R10 first batch", 100);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!done && cyc < 100);
      chk("R10 batch spacing", cyc, 21);
      chk("R9 balanced batch no step", int'(trim_code), t0);
      mode_track = 1'b0;
      @(negedge clk);
      wait_done("R10 final batch", 100);
      chk("R10 stop when mode low", int'(busy), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule